// File: doc/BRIEF.md
# Precision Time Counter with Staged Register Access

This block keeps a free-running time-of-day value made of a 48-bit seconds count and a 30-bit nanoseconds count. While it runs, it adds a nominal 8 ns on every clock cycle. A fractional rate trim can stretch or shrink that increment by one nanosecond on selected cycles, so the average tick can be tuned finely. The live time is presented on output ports so that neighbouring logic (timestamp capture, pulse generators) can sample it directly.

Software controls the counter through a small port of 16-bit registers. The absolute time is staged word by word and then committed all at once. Reading is coherent because a capture command freezes a copy of the counter, which software then reads word by word at leisure. Time can also be stepped by up to 15 whole seconds in either direction, or moved forward by up to 2^30-1 nanoseconds. Every action is a one-shot bit in a command word. Writing the command word changes the counter on the same clock edge.

Top module: `ptp_ltc`

## Requirements
- R1: After the synchronous reset `rst` the counter is stopped, seconds and nanoseconds read 0, the rate trim and its accumulator are 0, and every readable register returns 0.
- R2: Command word (address 0): bit 2 starts the counter and bit 1 stops it, and stop wins when both are set. Either change takes effect from the edge after the write. While running with no time-changing command, nanoseconds advance by 8 per cycle (with no rate trim), and while stopped the time holds.
- R3: Whenever an update would bring nanoseconds to 1,000,000,000 or more, 10^9 is removed (twice if needed) and the same count is carried into seconds on that same edge. Nanoseconds therefore always stay below 10^9.
- R4: Command bit 4 loads the staged time on the write edge, with the carry folding of R3 applied. Staging addresses: seconds at 1 (bits 15:0), 2 (bits 31:16) and 3 (bits 47:32); nanoseconds at 4 (bits 15:0) and 5 (bits 13:0 = ns bits 29:16). No 8 ns advance occurs on that edge.
- R5: Command bit 3 copies the time present just before the write edge into the capture registers. These read back at 10/11/12 (seconds low/middle/high) and 13/14 (ns bits 15:0 and ns bits 29:16 in bits 13:0). They stay frozen while the counter runs, until the next capture.
- R6: Command bit 5 steps seconds by the low 4 bits of the step-low word (address 6). If bit 15 of the step-high word (address 7) is 1, the step adds; if it is 0, the step subtracts. Nanoseconds stay unchanged and do not advance on that edge.
- R7: Command bit 6 adds the 30-bit magnitude {step-high[13:0], step-low} to nanoseconds, with the carry of R3, whatever the value of step-high bit 15. No 8 ns advance occurs on that edge.
- R8: Rate trim words: magnitude {rate-high[13:0], rate-low} at addresses 9 and 8, with rate-high bit 15 = 1 meaning faster. On every advancing cycle the magnitude is added to a 32-bit fraction accumulator. A carry out of the accumulator turns that cycle's increment into 9 ns (faster) or 7 ns (slower).
- R9: Command bit 0 clears the time, the rate trim and the accumulator, and stops the counter. It overrides every other bit of the same command write.
- R10: Among the time-changing bits, load wins over the seconds step, and the seconds step wins over the nanoseconds step. Command bits are one-shot: the command address reads 0, and the following cycles behave as a plain run.
- R11: Staging, step and rate registers read back the last value written, at the addresses listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock, one nominal 8 ns tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address for writes and reads |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| time_sec | output | 48 | Live seconds |
| time_ns | output | 30 | Live nanoseconds, always below 10^9 |
| running | output | 1 | Counter is advancing |

## Verification
Any register or command write acts on the rising edge that samples it. The new time, running flag and capture contents are therefore visible half a cycle later, at the next falling edge. Reads are combinational and are valid within the same low phase. The bench drives every write at a falling edge and records the live time there, because that value is what a capture, a step or a tick starts from. It then checks the result at the following falling edge. Rate-trim checks start with the accumulator cleared, start the counter, and compare the nanosecond gain after exactly 64 ticks: 8 carries occur in that window, so the expected gain is 520 ns when faster or 504 ns when slower.

// File: rtl/ptp_ltc_pkg.sv
package ptp_ltc_pkg;

    localparam int SEC_W      = 48;
    localparam int NS_W       = 30;
    localparam int WORD_W     = 16;
    localparam int ADDR_W     = 4;
    localparam int ACC_W      = 32;
    localparam int STEP_SEC_W = 4;
    localparam int INC_W      = 4;
    localparam int SUM_W      = NS_W + 2;
    localparam int NS_HI_BITS = NS_W - WORD_W;
    localparam int DIR_BIT    = WORD_W - 1;

    localparam logic [SUM_W-1:0] NS_PER_SEC  = SUM_W'(1_000_000_000);
    localparam logic [SUM_W-1:0] NS_PER_2SEC = SUM_W'(2_000_000_000);
    localparam logic [INC_W-1:0] INC_NOMINAL = INC_W'(8);

    localparam logic [ADDR_W-1:0] A_CMD      = 4'd0;
    localparam logic [ADDR_W-1:0] A_SET_S0   = 4'd1;
    localparam logic [ADDR_W-1:0] A_SET_S1   = 4'd2;
    localparam logic [ADDR_W-1:0] A_SET_S2   = 4'd3;
    localparam logic [ADDR_W-1:0] A_SET_N0   = 4'd4;
    localparam logic [ADDR_W-1:0] A_SET_N1   = 4'd5;
    localparam logic [ADDR_W-1:0] A_STEP_LO  = 4'd6;
    localparam logic [ADDR_W-1:0] A_STEP_HI  = 4'd7;
    localparam logic [ADDR_W-1:0] A_RATE_LO  = 4'd8;
    localparam logic [ADDR_W-1:0] A_RATE_HI  = 4'd9;
    localparam logic [ADDR_W-1:0] A_CAP_S0   = 4'd10;
    localparam logic [ADDR_W-1:0] A_CAP_S1   = 4'd11;
    localparam logic [ADDR_W-1:0] A_CAP_S2   = 4'd12;
    localparam logic [ADDR_W-1:0] A_CAP_N0   = 4'd13;
    localparam logic [ADDR_W-1:0] A_CAP_N1   = 4'd14;

    typedef struct packed {
        logic step_ns;
        logic step_sec;
        logic load;
        logic capture;
        logic start;
        logic stop;
        logic clear;
    } cmd_t;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } ptp_time_t;

    typedef struct packed {
        logic [1:0]      carry;
        logic [NS_W-1:0] ns;
    } ns_fold_t;

    function automatic cmd_t decode_cmd(input logic [WORD_W-1:0] w);
        cmd_t c;
        c.clear    = w[0];
        c.stop     = w[1];
        c.start    = w[2];
        c.capture  = w[3];
        c.load     = w[4];
        c.step_sec = w[5];
        c.step_ns  = w[6];
        return c;
    endfunction

    function automatic ns_fold_t fold_ns(input logic [SUM_W-1:0] v);
        ns_fold_t         r;
        logic [SUM_W-1:0] t;
        if (v >= NS_PER_2SEC) begin
            t       = v - NS_PER_2SEC;
            r.carry = 2'd2;
        end else if (v >= NS_PER_SEC) begin
            t       = v - NS_PER_SEC;
            r.carry = 2'd1;
        end else begin
            t       = v;
            r.carry = 2'd0;
        end
        r.ns = t[NS_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/ptp_ltc_regs.sv
module ptp_ltc_regs
    import ptp_ltc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    input  ptp_time_t             live_time,
    output cmd_t                  cmd,
    output ptp_time_t             set_time,
    output logic [STEP_SEC_W-1:0] step_secs,
    output logic [NS_W-1:0]       step_mag,
    output logic                  step_add,
    output logic [NS_W-1:0]       rate_mag,
    output logic                  rate_fast
);

    logic [WORD_W-1:0] set_s0, set_s1, set_s2, set_n0, set_n1;
    logic [WORD_W-1:0] step_lo, step_hi, rate_lo, rate_hi;
    ptp_time_t         cap;

    assign cmd = (bus_wr && bus_addr == A_CMD) ? decode_cmd(bus_wdata) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            set_s0  <= '0;
            set_s1  <= '0;
            set_s2  <= '0;
            set_n0  <= '0;
            set_n1  <= '0;
            step_lo <= '0;
            step_hi <= '0;
            rate_lo <= '0;
            rate_hi <= '0;
            cap     <= '0;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    A_SET_S0:  set_s0  <= bus_wdata;
                    A_SET_S1:  set_s1  <= bus_wdata;
                    A_SET_S2:  set_s2  <= bus_wdata;
                    A_SET_N0:  set_n0  <= bus_wdata;
                    A_SET_N1:  set_n1  <= bus_wdata;
                    A_STEP_LO: step_lo <= bus_wdata;
                    A_STEP_HI: step_hi <= bus_wdata;
                    A_RATE_LO: rate_lo <= bus_wdata;
                    A_RATE_HI: rate_hi <= bus_wdata;
                    default: ;
                endcase
            end
            if (cmd.clear) begin
                rate_lo <= '0;
                rate_hi <= '0;
            end
            if (cmd.capture) cap <= live_time;
        end
    end

    assign set_time.sec = {set_s2, set_s1, set_s0};
    assign set_time.ns  = {set_n1[NS_HI_BITS-1:0], set_n0};
    assign step_secs    = step_lo[STEP_SEC_W-1:0];
    assign step_mag     = {step_hi[NS_HI_BITS-1:0], step_lo};
    assign step_add     = step_hi[DIR_BIT];
    assign rate_mag     = {rate_hi[NS_HI_BITS-1:0], rate_lo};
    assign rate_fast    = rate_hi[DIR_BIT];

    always_comb begin
        case (bus_addr)
            A_SET_S0:  bus_rdata = set_s0;
            A_SET_S1:  bus_rdata = set_s1;
            A_SET_S2:  bus_rdata = set_s2;
            A_SET_N0:  bus_rdata = set_n0;
            A_SET_N1:  bus_rdata = set_n1;
            A_STEP_LO: bus_rdata = step_lo;
            A_STEP_HI: bus_rdata = step_hi;
            A_RATE_LO: bus_rdata = rate_lo;
            A_RATE_HI: bus_rdata = rate_hi;
            A_CAP_S0:  bus_rdata = cap.sec[WORD_W-1:0];
            A_CAP_S1:  bus_rdata = cap.sec[2*WORD_W-1:WORD_W];
            A_CAP_S2:  bus_rdata = cap.sec[3*WORD_W-1:2*WORD_W];
            A_CAP_N0:  bus_rdata = cap.ns[WORD_W-1:0];
            A_CAP_N1:  bus_rdata = WORD_W'(cap.ns[NS_W-1:WORD_W]);
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ptp_ltc_rate.sv
module ptp_ltc_rate
    import ptp_ltc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    input  logic [NS_W-1:0]  rate_mag,
    input  logic             rate_fast,
    output logic [INC_W-1:0] inc
);

    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   sum;

    assign sum = {1'b0, acc} + (ACC_W+1)'(rate_mag);

    always_comb begin
        if (!sum[ACC_W])   inc = INC_NOMINAL;
        else if (rate_fast) inc = INC_NOMINAL + INC_W'(1);
        else               inc = INC_NOMINAL - INC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) acc <= '0;
        else if (advance) acc <= sum[ACC_W-1:0];
    end

endmodule

// File: rtl/ptp_ltc_core.sv
module ptp_ltc_core
    import ptp_ltc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  cmd_t                  cmd,
    input  ptp_time_t             set_time,
    input  logic [STEP_SEC_W-1:0] step_secs,
    input  logic [NS_W-1:0]       step_mag,
    input  logic                  step_add,
    input  logic [INC_W-1:0]      inc,
    output ptp_time_t             cur,
    output logic                  running,
    output logic                  advance
);

    ptp_time_t nxt;
    ns_fold_t  f;
    logic      modify;

    assign modify  = cmd.load | cmd.step_sec | cmd.step_ns;
    assign advance = running & ~cmd.clear & ~modify;

    always_comb begin
        nxt = cur;
        f   = '0;
        if (cmd.load) begin
            f       = fold_ns(SUM_W'(set_time.ns));
            nxt.sec = set_time.sec + SEC_W'(f.carry);
            nxt.ns  = f.ns;
        end else if (cmd.step_sec) begin
            if (step_add) nxt.sec = cur.sec + SEC_W'(step_secs);
            else          nxt.sec = cur.sec - SEC_W'(step_secs);
        end else if (cmd.step_ns) begin
            f       = fold_ns(SUM_W'(cur.ns) + SUM_W'(step_mag));
            nxt.sec = cur.sec + SEC_W'(f.carry);
            nxt.ns  = f.ns;
        end else if (running) begin
            f       = fold_ns(SUM_W'(cur.ns) + SUM_W'(inc));
            nxt.sec = cur.sec + SEC_W'(f.carry);
            nxt.ns  = f.ns;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.clear) begin
            cur     <= '0;
            running <= 1'b0;
        end else begin
            cur <= nxt;
            if (cmd.stop)       running <= 1'b0;
            else if (cmd.start) running <= 1'b1;
        end
    end

endmodule

// File: rtl/ptp_ltc.sv
module ptp_ltc
    import ptp_ltc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [SEC_W-1:0]  time_sec,
    output logic [NS_W-1:0]   time_ns,
    output logic              running
);

    cmd_t                  cmd;
    ptp_time_t             set_time;
    ptp_time_t             cur;
    logic [STEP_SEC_W-1:0] step_secs;
    logic [NS_W-1:0]       step_mag;
    logic                  step_add;
    logic [NS_W-1:0]       rate_mag;
    logic                  rate_fast;
    logic [INC_W-1:0]      inc;
    logic                  advance;

    ptp_ltc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .live_time (cur),
        .cmd       (cmd),
        .set_time  (set_time),
        .step_secs (step_secs),
        .step_mag  (step_mag),
        .step_add  (step_add),
        .rate_mag  (rate_mag),
        .rate_fast (rate_fast)
    );

    ptp_ltc_rate u_rate (
        .clk       (clk),
        .rst       (rst),
        .clear     (cmd.clear),
        .advance   (advance),
        .rate_mag  (rate_mag),
        .rate_fast (rate_fast),
        .inc       (inc)
    );

    ptp_ltc_core u_core (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .set_time  (set_time),
        .step_secs (step_secs),
        .step_mag  (step_mag),
        .step_add  (step_add),
        .inc       (inc),
        .cur       (cur),
        .running   (running),
        .advance   (advance)
    );

    assign time_sec = cur.sec;
    assign time_ns  = cur.ns;

endmodule

// File: rtl/ptp_ltc_checker.sv
module ptp_ltc_checker
    import ptp_ltc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [SEC_W-1:0]  time_sec,
    input logic [NS_W-1:0]   time_ns,
    input logic              running
);

    localparam logic [NS_W-1:0] NS_LIMIT = NS_W'(1_000_000_000);
    localparam logic [NS_W-1:0] NS_SAFE  = NS_W'(999_999_000);

    p_ns_range_r3: assert property (@(posedge clk) disable iff (rst)
        time_ns < NS_LIMIT);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!running && !bus_wr) |=> ($stable(time_sec) && $stable(time_ns)));

    p_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (running && !bus_wr && time_ns < NS_SAFE) |=>
        ((time_ns - $past(time_ns)) >= NS_W'(7) &&
         (time_ns - $past(time_ns)) <= NS_W'(9) &&
         time_sec == $past(time_sec)));

    p_stop_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CMD && bus_wdata[1]) |=> !running);

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CMD && bus_wdata[0]) |=>
        (time_sec == '0 && time_ns == '0 && !running));

endmodule

bind ptp_ltc ptp_ltc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .time_sec  (time_sec),
    .time_ns   (time_ns),
    .running   (running)
);

// File: tb/ptp_ltc_bench.sv
module ptp_ltc_bench;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic        bus_wr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [47:0] time_sec;
    logic [29:0] time_ns;
    logic        running;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;
    longint      pre_sec, pre_ns;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptp_ltc u_ptp_ltc (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .time_sec  (time_sec),
        .time_ns   (time_ns),
        .running   (running)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        pre_sec   = longint'(time_sec);
        pre_ns    = longint'(time_ns);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output longint v);
        bus_addr = a;
        #1;
        v = longint'(bus_rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stage_time(input longint s, input longint ns);
        wr(4'd1, 16'(s));
        wr(4'd2, 16'(s >> 16));
        wr(4'd3, 16'(s >> 32));
        wr(4'd4, 16'(ns));
        wr(4'd5, 16'(ns >> 16));
    endtask

    task automatic t_reset;
        longint v;
        chk("R1 sec", longint'(time_sec), 0);
        chk("R1 ns", longint'(time_ns), 0);
        chk("R1 running", longint'(running), 0);
        rd(4'd13, v); chk("R1 capture ns", v, 0);
        rd(4'd9, v);  chk("R1 rate hi", v, 0);
        rd(4'd0, v);  chk("R10 command reads zero", v, 0);
        idle(5);
        chk("R2 stopped holds", longint'(time_ns), 0);
    endtask

    task automatic t_start;
        longint t0;
        wr(4'd0, 16'h0004);
        chk("R2 running", longint'(running), 1);
        t0 = longint'(time_ns);
        idle(10);
        chk("R2 8ns per cycle", longint'(time_ns) - t0, 80);
    endtask

    task automatic t_load_carry;
        stage_time(64'h0001_0002_0003, 999_999_992);
        wr(4'd0, 16'h0010);
        chk("R4 loaded sec", longint'(time_sec), 64'h0001_0002_0003);
        chk("R4 loaded ns", longint'(time_ns), 999_999_992);
        idle(1);
        chk("R3 ns wraps", longint'(time_ns), 0);
        chk("R3 carry into sec", longint'(time_sec), 64'h0001_0002_0004);
    endtask

    task automatic t_capture;
        longint es, en, v, w, x;
        wr(4'd0, 16'h0008);
        es = pre_sec; en = pre_ns;
        idle(7);
        rd(4'd10, v); rd(4'd11, w); rd(4'd12, x);
        chk("R5 captured sec", (x << 32) | (w << 16) | v, es);
        rd(4'd13, v); rd(4'd14, w);
        chk("R5 captured ns", (w << 16) | v, en);
        chk("R5 live moved on", longint'(time_ns) - en, 64);
    endtask

    task automatic t_sec_step;
        wr(4'd6, 16'd5);
        wr(4'd7, 16'h8000);
        wr(4'd0, 16'h0020);
        chk("R6 add sec", longint'(time_sec), pre_sec + 5);
        chk("R6 ns unchanged", longint'(time_ns), pre_ns);
        wr(4'd6, 16'd3);
        wr(4'd7, 16'h0000);
        wr(4'd0, 16'h0020);
        chk("R6 subtract sec", longint'(time_sec), pre_sec - 3);
        wr(4'd6, 16'h0015);
        wr(4'd7, 16'h8000);
        wr(4'd0, 16'h0020);
        chk("R6 low 4 bits only", longint'(time_sec), pre_sec + 5);
    endtask

    function automatic longint fold_ns(input longint v);
        return (v >= 2_000_000_000) ? v - 2_000_000_000 :
               (v >= 1_000_000_000) ? v - 1_000_000_000 : v;
    endfunction

    function automatic longint carry_of(input longint v);
        return (v >= 2_000_000_000) ? 2 : (v >= 1_000_000_000) ? 1 : 0;
    endfunction

    task automatic t_ns_step;
        longint v;
        wr(4'd6, 16'h657B);
        wr(4'd7, 16'h1DCD);
        wr(4'd0, 16'h0040);
        v = pre_ns + 500_000_123;
        chk("R7 add despite dir 0", longint'(time_ns), fold_ns(v));
        chk("R7 sec carry", longint'(time_sec), pre_sec + carry_of(v));
        wr(4'd6, 16'hFFFF);
        wr(4'd7, 16'hBFFF);
        stage_time(64'h10, 999_999_999);
        wr(4'd0, 16'h0010);
        wr(4'd0, 16'h0040);
        chk("R7 double carry ns", longint'(time_ns), 73_741_822);
        chk("R7 double carry sec", longint'(time_sec), 64'h12);
    endtask

    task automatic t_priority;
        wr(4'd0, 16'h0070);
        chk("R10 load wins sec", longint'(time_sec), 64'h10);
        chk("R10 load wins ns", longint'(time_ns), 999_999_999);
        idle(1);
        chk("R10 one-shot then tick", longint'(time_ns), 7);
        chk("R10 one-shot tick sec", longint'(time_sec), 64'h11);
    endtask

    task automatic t_stop;
        longint s, n;
        wr(4'd0, 16'h0006);
        chk("R2 stop wins", longint'(running), 0);
        s = longint'(time_sec); n = longint'(time_ns);
        idle(6);
        chk("R2 frozen ns", longint'(time_ns), n);
        chk("R2 frozen sec", longint'(time_sec), s);
    endtask

    task automatic t_clear;
        longint t0, v;
        wr(4'd8, 16'h1234);
        wr(4'd9, 16'h8010);
        rd(4'd9, v); chk("R11 rate hi readback", v, 16'h8010);
        rd(4'd3, v); chk("R11 staged sec hi readback", v, 0);
        wr(4'd0, 16'h0015);
        chk("R9 clear sec", longint'(time_sec), 0);
        chk("R9 clear ns", longint'(time_ns), 0);
        chk("R9 clear stops", longint'(running), 0);
        rd(4'd9, v); chk("R9 rate cleared", v, 0);
        wr(4'd0, 16'h0004);
        t0 = longint'(time_ns);
        idle(20);
        chk("R9 untrimmed after clear", longint'(time_ns) - t0, 160);
    endtask

    task automatic t_rate;
        longint t0;
        wr(4'd0, 16'h0001);
        wr(4'd9, 16'hA000);
        wr(4'd8, 16'h0000);
        wr(4'd0, 16'h0004);
        t0 = longint'(time_ns);
        idle(64);
        chk("R8 faster gain", longint'(time_ns) - t0, 520);
        wr(4'd0, 16'h0001);
        wr(4'd9, 16'h2000);
        wr(4'd0, 16'h0004);
        t0 = longint'(time_ns);
        idle(64);
        chk("R8 slower gain", longint'(time_ns) - t0, 504);
    endtask

    initial begin
        rst       = 1'b1;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_start;
        t_load_carry;
        t_capture;
        t_sec_step;
        t_ns_step;
        t_priority;
        t_stop;
        t_clear;
        t_rate;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule